// File: doc/BRIEF.md
# Housekeeping Command Dispatcher

This block sits between a host write bus and a set of maintenance routine engines for an associative lookup array. The host starts a routine by writing to one of seven command addresses. Only the address selects the action, and the data word on the bus plays no part. Four addresses start a table routine: add an entry, delete an entry, read an entry, or set the add pointer. The other three addresses step 8-bit age counters. One steps the time-stamp counter. One steps the purge counter and then starts the purge routine. One steps both counters and then starts the purge routine.

Each routine engine is reached through a one-cycle start pulse and a shared done input, and only one routine runs at a time. The processor-ready output tells the host when it may issue the next command. It falls after each accepted command and rises again once the routine has reported done. It also stays low while the search logic signals that a high-priority address search is pending. A write made while ready is low is discarded.

Top module: `hk_cmd_dispatch`

## Requirements
- R1: After reset, `ts_count` and `pr_count` are 0, `rtn_start` is 0, and `proc_rdy` is 1 while `busy_hi_pri` is low.
- R2: An accepted write to address 0 (add), 1 (delete), 2 (read) or 3 (set-add) drives `rtn_start` bit 0, 1, 2 or 3 respectively for exactly one cycle, in the cycle after the write.
- R3: The value on `wr_data` has no effect on which routine starts or on the counters.
- R4: An accepted write to address 4 increments `ts_count` by one in the cycle after the write, starts no routine, and holds `proc_rdy` low for exactly that one cycle.
- R5: An accepted write to address 5 increments `pr_count` by one and pulses `rtn_start` bit 4 (purge), both in the cycle after the write.
- R6: An accepted write to address 6 increments both counters by one and pulses `rtn_start` bit 4, both in the cycle after the write.
- R7: Both counters are 8 bits wide and wrap from 255 to 0.
- R8: After an accepted routine command, `proc_rdy` is low from the next cycle until `rtn_done` is sampled high, and it is high in the cycle after that edge if `busy_hi_pri` is low.
- R9: `proc_rdy` is low whenever `busy_hi_pri` is high. A write is accepted only when `proc_rdy` is high, and any other write leaves the counters and `rtn_start` unchanged.
- R10: A write to address 7 is ignored: no start pulse, no counter change, and `proc_rdy` stays high.
- R11: `rtn_done` sampled while no routine is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Command address |
| wr_data | input | 16 | Write data (ignored) |
| busy_hi_pri | input | 1 | High-priority search pending |
| rtn_done | input | 1 | Running routine has finished |
| rtn_start | output | 5 | One-cycle start pulses: add, delete, read, set-add, purge |
| proc_rdy | output | 1 | Host may issue a command |
| ts_count | output | 8 | Time-stamp counter |
| pr_count | output | 8 | Purge counter |

## Verification
Start pulses, counter steps and the fall of `proc_rdy` all come from one register stage, so they are due one cycle after the write edge. The return of `proc_rdy` is due one cycle after the edge that samples `rtn_done`. The only same-cycle result is the masking of `proc_rdy` by `busy_hi_pri`. The bench drives inputs on the falling edge and samples each result on the falling edge that follows the rising edge where it is due. It then checks again one cycle later, which shows that each pulse lasts one cycle and that a dropped write leaves no trace.

// File: rtl/hk_cmd_dispatch.sv
module hk_cmd_dispatch #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16,
  parameter int N_RTN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_hi_pri,
  input  logic              rtn_done,
  output logic [N_RTN-1:0]  rtn_start,
  output logic              proc_rdy,
  output logic [CNT_W-1:0]  ts_count,
  output logic [CNT_W-1:0]  pr_count
);
  localparam int PURGE = N_RTN - 1;

  typedef enum logic [1:0] {IDLE, RUN, SETTLE} state_t;
  state_t st;

  logic accept;
  logic unused_data;

  assign unused_data = ^wr_data;
  assign proc_rdy    = (st == IDLE) && !busy_hi_pri;
  assign accept      = wr_en && proc_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      rtn_start <= '0;
      ts_count  <= '0;
      pr_count  <= '0;
    end else begin
      rtn_start <= '0;
      case (st)
        IDLE: if (accept) begin
          case (wr_addr)
            3'd0, 3'd1, 3'd2, 3'd3: begin
              rtn_start[wr_addr[1:0]] <= 1'b1;
              st <= RUN;
            end
            3'd4: begin
              ts_count <= ts_count + 1'b1;
              st <= SETTLE;
            end
            3'd5: begin
              pr_count <= pr_count + 1'b1;
              rtn_start[PURGE] <= 1'b1;
              st <= RUN;
            end
            3'd6: begin
              ts_count <= ts_count + 1'b1;
              pr_count <= pr_count + 1'b1;
              rtn_start[PURGE] <= 1'b1;
              st <= RUN;
            end
            default: ;
          endcase
        end
        RUN:     if (rtn_done) st <= IDLE;
        SETTLE:  st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hk_cmd_dispatch_chk.sv
module hk_cmd_dispatch_chk #(
  parameter int CNT_W = 8,
  parameter int N_RTN = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             busy_hi_pri,
  input logic [N_RTN-1:0] rtn_start,
  input logic             proc_rdy,
  input logic [CNT_W-1:0] ts_count,
  input logic [CNT_W-1:0] pr_count
);
  p_start_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rtn_start));

  p_start_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_rdy && wr_en && wr_addr < 3'd4) |=>
      (rtn_start == N_RTN'(1 << $past(wr_addr))));

  p_ts_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_rdy && wr_en && wr_addr == 3'd4) |=>
      (ts_count == $past(ts_count) + 1'b1 && rtn_start == '0));

  p_pr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_rdy && wr_en && wr_addr == 3'd5) |=>
      (pr_count == $past(pr_count) + 1'b1 && rtn_start[N_RTN-1]));

  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_rdy && wr_en && wr_addr != 3'd7) |=> !proc_rdy);

  p_pri_blocks_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hi_pri |-> !proc_rdy);

  p_blocked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_rdy |=> ($stable(ts_count) && $stable(pr_count) && rtn_start == '0));

  p_addr7_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_rdy && wr_en && wr_addr == 3'd7) |=>
      ($stable(ts_count) && $stable(pr_count) && rtn_start == '0));
endmodule

bind hk_cmd_dispatch hk_cmd_dispatch_chk #(.CNT_W(CNT_W), .N_RTN(N_RTN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy_hi_pri(busy_hi_pri), .rtn_start(rtn_start), .proc_rdy(proc_rdy),
  .ts_count(ts_count), .pr_count(pr_count)
);

// File: tb/hk_cmd_dispatch_bench.sv
module hk_cmd_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy_hi_pri = 1'b0;
  logic        rtn_done = 1'b0;
  logic [4:0]  rtn_start;
  logic        proc_rdy;
  logic [7:0]  ts_count, pr_count;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_ts = 0, m_pr = 0;

  always #10 clk = ~clk;

  hk_cmd_dispatch u_hk_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_hi_pri(busy_hi_pri), .rtn_done(rtn_done), .rtn_start(rtn_start),
    .proc_rdy(proc_rdy), .ts_count(ts_count), .pr_count(pr_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [4:0] st, input logic rdy);
    check({req, " start"}, 32'(rtn_start), 32'(st));
    check({req, " ready"}, 32'(proc_rdy), 32'(rdy));
    check({req, " ts"}, 32'(ts_count), 32'(m_ts));
    check({req, " pr"}, 32'(pr_count), 32'(m_pr));
  endtask

  task automatic write_cmd(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_rtn();
    rtn_done = 1'b1;
    @(negedge clk);
    rtn_done = 1'b0;
  endtask

  task automatic t_reset();
    check_state("R1 reset", 5'b0, 1'b1);
  endtask

  task automatic t_routines();
    for (int a = 0; a < 4; a++) begin
      write_cmd(3'(a), 16'h1234);
      check_state("R2 start pulse", 5'(1 << a), 1'b0);
      @(negedge clk);
      check_state("R2 pulse ends", 5'b0, 1'b0);
      finish_rtn();
      check_state("R8 ready back", 5'b0, 1'b1);
    end
  endtask

  task automatic t_data_ignored();
    write_cmd(3'd2, 16'hFFFF);
    check_state("R3 data ffff", 5'b00100, 1'b0);
    finish_rtn();
    write_cmd(3'd4, 16'h0000);
    m_ts++;
    check_state("R3 data 0000", 5'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_inc_ts();
    write_cmd(3'd4, 16'hA5A5);
    m_ts++;
    check_state("R4 ts step", 5'b0, 1'b0);
    @(negedge clk);
    check_state("R4 ready after one", 5'b0, 1'b1);
  endtask

  task automatic t_inc_pr();
    write_cmd(3'd5, 16'h0001);
    m_pr++;
    check_state("R5 pr step purge", 5'b10000, 1'b0);
    @(negedge clk);
    check_state("R5 pulse ends", 5'b0, 1'b0);
    finish_rtn();
    check_state("R5 ready back", 5'b0, 1'b1);
  endtask

  task automatic t_inc_both();
    write_cmd(3'd6, 16'h5A5A);
    m_ts++; m_pr++;
    check_state("R6 both step purge", 5'b10000, 1'b0);
    finish_rtn();
    check_state("R6 ready back", 5'b0, 1'b1);
  endtask

  task automatic t_wrap();
    while (m_pr != 8'hFF) begin
      write_cmd(3'd6, 16'h0);
      m_ts++; m_pr++;
      finish_rtn();
    end
    check_state("R7 at 255", 5'b0, 1'b1);
    write_cmd(3'd5, 16'h0);
    m_pr++;
    check("R7 pr wraps", 32'(pr_count), 32'h0);
    finish_rtn();
    for (int i = 0; i < 256; i++) begin
      write_cmd(3'd4, 16'h0);
      @(negedge clk);
    end
    check("R7 ts full lap", 32'(ts_count), 32'(m_ts));
  endtask

  task automatic t_ready_hold();
    write_cmd(3'd0, 16'h0);
    repeat (5) @(negedge clk);
    check_state("R8 held while running", 5'b0, 1'b0);
    write_cmd(3'd4, 16'h0);
    check_state("R9 write while busy dropped", 5'b0, 1'b0);
    finish_rtn();
    check_state("R8 done returns ready", 5'b0, 1'b1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    busy_hi_pri = 1'b1;
    #1;
    check("R9 ready masked", 32'(proc_rdy), 32'h0);
    write_cmd(3'd6, 16'h0);
    check_state("R9 write under priority dropped", 5'b0, 1'b0);
    busy_hi_pri = 1'b0;
    #1;
    check_state("R9 ready after priority", 5'b0, 1'b1);
    write_cmd(3'd1, 16'h0);
    busy_hi_pri = 1'b1;
    finish_rtn();
    check_state("R9 done but priority pending", 5'b0, 1'b0);
    busy_hi_pri = 1'b0;
    #1;
    check_state("R9 ready released", 5'b0, 1'b1);
  endtask

  task automatic t_addr7();
    write_cmd(3'd7, 16'hBEEF);
    check_state("R10 addr 7 ignored", 5'b0, 1'b1);
  endtask

  task automatic t_stray_done();
    @(negedge clk);
    finish_rtn();
    check_state("R11 stray done", 5'b0, 1'b1);
    write_cmd(3'd3, 16'h0);
    check_state("R11 later command ok", 5'b01000, 1'b0);
    finish_rtn();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_routines();
    t_data_ignored();
    t_inc_ts();
    t_inc_pr();
    t_inc_both();
    t_ready_hold();
    t_priority();
    t_addr7();
    t_stray_done();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule